// File: doc/BRIEF.md
# Transmit Character Queue with Status Flags

This block queues characters from a host write port until the serializer side takes them. Each entry is nine bits: eight data bits plus one control bit. Two status flags come out of it. The first is an active-low flag that reports the queue is at least half full. The second is an "empty" flag whose active level and meaning change with three configuration inputs.

The queue can be emptied with a flush input. The flush acts only after that input has been held for a minimum number of cycles. A pass-through mode leaves the stored contents untouched. In that mode the empty flag shows whether the downstream transmitter is ready to take a character. During a self-test run, reads are held off, and the empty flag shows a one-cycle marker at the end of each test pattern.

Storage is a single-clock, synchronously read memory. All flags are registered.

Top module: `txq_fifo`

## Requirements
- R1: `half_n_o` is 0 exactly when the stored count is `DEPTH/2` (128) or more. It is 1 otherwise, whatever `cascade_i` is.
- R2: `empty_o` carries an internal "asserted" state. That state is driven high when `cascade_i`=1 and driven low when `cascade_i`=0.
- R3: In queue mode (`bypass_i`=0, `selftest_i`=0), empty is asserted one edge after the count reaches zero. The count reaches zero at reset, after the last read, or after a flush. A read (`rd_en_i`=1) returns entries in write order, with `rd_valid_o`=1 and `rd_data_o` valid after the same edge.
- R4: The flush acts on the edge after `flush_i` has been sampled high on 8 consecutive edges. It clears the count and both pointers, and it keeps them clear until `flush_i` falls. A hold of 8 edges or fewer has no effect, and `flush_i` is ignored while `bypass_i`=1.
- R5: While `bypass_i`=1, empty follows `tx_ready_i` one edge later. In this mode, writes and reads leave the stored entries and the count unchanged.
- R6: While `selftest_i`=1, reads are suspended. Empty is asserted for exactly one cycle, one edge after each single-cycle `st_done_i` pulse, in either queue or pass-through mode.
- R7: A write while the count equals `DEPTH` is dropped, and the stored entries are kept. `ovf_o` is set and stays set until `rst`.
- R8: A read and a write on the same edge, on a queue that is neither empty nor full, leave the count unchanged.
- R9: A read request on an empty queue is ignored: `rd_valid_o` stays 0 and the count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cascade_i | input | 1 | 1: empty flag active high; 0: active low |
| bypass_i | input | 1 | Pass-through mode; storage frozen |
| selftest_i | input | 1 | Self-test active; reads suspended |
| st_done_i | input | 1 | One-cycle pulse at end of each self-test pattern |
| tx_ready_i | input | 1 | Downstream transmitter can take a character |
| flush_i | input | 1 | Flush request; must be held to act |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 9 | Write character (control bit in bit 8) |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 9 | Read character |
| rd_valid_o | output | 1 | `rd_data_o` holds a character read on the last edge |
| half_n_o | output | 1 | Half-full flag, active low |
| empty_o | output | 1 | Empty / ready / self-test marker, polarity per `cascade_i` |
| ovf_o | output | 1 | Sticky write-while-full indication |

## Verification
The assertions assume that `st_done_i` is a single-cycle pulse. They also assume that mode inputs change only between operations, not in the same cycle as a flush hold that is about to complete. The stimulus keeps to this in three ways:
- It changes `bypass_i`, `selftest_i` and `cascade_i` only while `flush_i` is low.
- It raises `st_done_i` for one cycle at a time.
- It drives every input away from the active edge.

With those conditions met, the checks on count, pointers and the sticky overflow describe only how the queue itself behaves.

// File: rtl/txq_pkg.sv
package txq_pkg;
  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/txq_flush.sv
module txq_flush #(
  parameter int unsigned HOLD = 8,
  localparam int unsigned HW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_i,
  input  logic bypass_i,
  output logic flush_act
);
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst || !flush_i || bypass_i) hold_q <= '0;
    else if (hold_q != HW'(HOLD)) hold_q <= hold_q + 1'b1;
  end

  assign flush_act = flush_i && !bypass_i && (hold_q == HW'(HOLD));

  // R4
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    flush_act |-> $past(flush_i));
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = cnt_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_act,
  input  logic          bypass_i,
  input  logic          selftest_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic [AW-1:0] wptr_q,
  output logic [AW-1:0] rptr_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          rd_valid_q,
  output logic          ovf_q
);
  logic full, empty;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = wr_en_i && !full && !flush_act && !bypass_i;
  assign rd_ok = rd_en_i && !empty && !flush_act && !bypass_i && !selftest_i;

  always_comb begin
    cnt_nxt = cnt_q;
    if (flush_act)          cnt_nxt = '0;
    else if (wr_ok && !rd_ok) cnt_nxt = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0; rptr_q <= '0; cnt_q <= '0;
      rd_valid_q <= 1'b0; ovf_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_nxt;
      rd_valid_q <= rd_ok;
      if (flush_act) begin
        wptr_q <= '0; rptr_q <= '0;
      end else begin
        if (wr_ok) wptr_q <= wptr_q + 1'b1;
        if (rd_ok) rptr_q <= rptr_q + 1'b1;
      end
      if (wr_en_i && full && !flush_act && !bypass_i) ovf_q <= 1'b1;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  // R4
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush_act |=> (cnt_q == '0 && rptr_q == wptr_q));
  // R6
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (selftest_i && !flush_act) |=> $stable(rptr_q));
  // R8
  same_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && wr_ok) |=> $stable(cnt_q));
  // R9
  empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |=> !rd_valid_q);
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int unsigned CW   = 9,
  parameter int unsigned HALF = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          cascade_i,
  input  logic          bypass_i,
  input  logic          selftest_i,
  input  logic          st_done_i,
  input  logic          tx_ready_i,
  output logic          half_n_o,
  output logic          empty_o
);
  logic empty_act_q, empty_act_d;

  always_comb begin
    if (selftest_i)    empty_act_d = st_done_i;
    else if (bypass_i) empty_act_d = tx_ready_i;
    else               empty_act_d = (cnt_nxt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_n_o    <= 1'b1;
      empty_act_q <= 1'b1;
    end else begin
      half_n_o    <= (cnt_nxt < CW'(HALF));
      empty_act_q <= empty_act_d;
    end
  end

  assign empty_o = cascade_i ? empty_act_q : ~empty_act_q;

  // R6
  st_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (selftest_i && $past(selftest_i) && empty_act_q && !st_done_i && selftest_i) |=> !empty_act_q || !selftest_i);
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo
  import txq_pkg::*;
#(
  parameter int unsigned DATA_W = 9,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned HOLD   = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = cnt_bits(DEPTH),
  localparam int unsigned HALF  = DEPTH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cascade_i,
  input  logic              bypass_i,
  input  logic              selftest_i,
  input  logic              st_done_i,
  input  logic              tx_ready_i,
  input  logic              flush_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              half_n_o,
  output logic              empty_o,
  output logic              ovf_o
);
  logic          flush_act, wr_ok, rd_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt;

  txq_flush #(.HOLD(HOLD)) u_flush (
    .clk(clk), .rst(rst), .flush_i(flush_i), .bypass_i(bypass_i),
    .flush_act(flush_act));

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .flush_act(flush_act), .bypass_i(bypass_i),
    .selftest_i(selftest_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr_q(wptr), .rptr_q(rptr),
    .cnt_q(cnt), .cnt_nxt(cnt_nxt), .rd_valid_q(rd_valid_o), .ovf_q(ovf_o));

  txq_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(wptr), .wdata(wr_data_i),
    .re(rd_ok), .raddr(rptr), .rdata(rd_data_o));

  txq_flags #(.CW(CW), .HALF(HALF)) u_flags (
    .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .cascade_i(cascade_i),
    .bypass_i(bypass_i), .selftest_i(selftest_i), .st_done_i(st_done_i),
    .tx_ready_i(tx_ready_i), .half_n_o(half_n_o), .empty_o(empty_o));

  // R1
  half_flag_chk: assert property (@(posedge clk) disable iff (rst)
    half_n_o == (cnt < CW'(HALF)));
  // R2
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    (!bypass_i && !selftest_i && $past(!bypass_i && !selftest_i) && cnt != '0)
      |-> (empty_o == !cascade_i));
endmodule

// File: tb/txq_fifo_bench.sv
module txq_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cascade_i = 1'b1, bypass_i = 1'b0, selftest_i = 1'b0, st_done_i = 1'b0;
  logic tx_ready_i = 1'b0, flush_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [8:0] wr_data_i = '0;
  logic [8:0] rd_data_o;
  logic rd_valid_o, half_n_o, empty_o, ovf_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  txq_fifo u_txq_fifo (.*);

  typedef struct packed {
    logic       wr; logic rd; logic [8:0] d;
    logic       ev; logic [8:0] ed; logic ee;
  } vec_t;
  localparam vec_t VT [8] = '{
    '{1'b1, 1'b0, 9'h0A1, 1'b0, 9'h000, 1'b0},
    '{1'b1, 1'b0, 9'h1A2, 1'b0, 9'h000, 1'b0},
    '{1'b0, 1'b1, 9'h000, 1'b1, 9'h0A1, 1'b0},
    '{1'b1, 1'b1, 9'h0A3, 1'b1, 9'h1A2, 1'b0},
    '{1'b0, 1'b1, 9'h000, 1'b1, 9'h0A3, 1'b1},
    '{1'b0, 1'b1, 9'h000, 1'b0, 9'h000, 1'b1},
    '{1'b1, 1'b1, 9'h1A4, 1'b0, 9'h000, 1'b0},
    '{1'b0, 1'b1, 9'h000, 1'b1, 9'h1A4, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    wr_en_i = 0; rd_en_i = 0; st_done_i = 0;
  endtask

  task automatic push(input logic [8:0] d);
    wr_en_i = 1; wr_data_i = d; step(); wr_en_i = 0;
  endtask

  task automatic pop_chk(input string req, input logic [8:0] d);
    rd_en_i = 1; step(); rd_en_i = 0;
    chk(req, {23'd0, rd_valid_o, rd_data_o}, {23'd0, 1'b1, d});
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(); step();
    rst = 0;
    // R3 reset state; R2 cascade polarity high
    chk("R3 reset empty", {31'd0, empty_o}, 1);
    chk("R1 reset half", {31'd0, half_n_o}, 1);
    chk("R7 reset ovf", {31'd0, ovf_o}, 0);

    // R3 R8 R9 table walk
    foreach (VT[i]) begin
      wr_en_i = VT[i].wr; rd_en_i = VT[i].rd; wr_data_i = VT[i].d;
      step(); idle();
      chk("R8 R9 valid", {31'd0, rd_valid_o}, {31'd0, VT[i].ev});
      if (VT[i].ev) chk("R3 order", {23'd0, rd_data_o}, {23'd0, VT[i].ed});
      chk("R3 empty", {31'd0, empty_o}, {31'd0, VT[i].ee});
    end

    // R2 low-active polarity
    cascade_i = 0; #1;
    chk("R2 active low empty", {31'd0, empty_o}, 0);
    push(9'h055);
    chk("R2 active low not empty", {31'd0, empty_o}, 1);
    cascade_i = 1; #1;
    chk("R2 active high not empty", {31'd0, empty_o}, 0);
    pop_chk("R3 pop", 9'h055);

    // R1 half flag boundary
    for (int i = 0; i < 127; i++) push(9'(i));
    chk("R1 at 127", {31'd0, half_n_o}, 1);
    push(9'h07F);
    chk("R1 at 128", {31'd0, half_n_o}, 0);
    pop_chk("R1 pop", 9'h000);
    chk("R1 back to 127", {31'd0, half_n_o}, 1);

    // R4 flush held 8 edges: no effect
    flush_i = 1; repeat (8) step(); flush_i = 0; step();
    chk("R4 short hold", {31'd0, empty_o}, 0);
    // R4 flush held 9 edges: clears
    flush_i = 1; repeat (9) step();
    chk("R4 flush clears", {31'd0, empty_o}, 1);
    push(9'h011);
    chk("R4 held flush blocks write", {31'd0, empty_o}, 1);
    flush_i = 0; step();
    chk("R4 after release", {31'd0, half_n_o}, 1);

    // R7 fill to full, overflow, no corruption
    for (int i = 0; i < 256; i++) push({i[0], i[7:0]});
    chk("R7 no ovf at full", {31'd0, ovf_o}, 0);
    push(9'h1FF);
    chk("R7 ovf set", {31'd0, ovf_o}, 1);
    begin
      int errs = 0;
      for (int i = 0; i < 256; i++) begin
        rd_en_i = 1; step(); rd_en_i = 0;
        if (!rd_valid_o || rd_data_o !== {i[0], i[7:0]}) errs++;
      end
      chk("R7 contents kept", errs, 0);
    end
    chk("R7 drained empty", {31'd0, empty_o}, 1);
    chk("R7 ovf sticky", {31'd0, ovf_o}, 1);

    // R6 self-test: reads suspended, one-cycle marker
    push(9'h0C1); push(9'h0C2);
    selftest_i = 1; rd_en_i = 1; step(); step();
    chk("R6 read suspended", {31'd0, rd_valid_o}, 0);
    chk("R6 no marker", {31'd0, empty_o}, 0);
    rd_en_i = 0; st_done_i = 1; step(); st_done_i = 0;
    chk("R6 marker on", {31'd0, empty_o}, 1);
    step();
    chk("R6 marker one cycle", {31'd0, empty_o}, 0);
    cascade_i = 0; st_done_i = 1; step(); st_done_i = 0;
    chk("R6 marker low active", {31'd0, empty_o}, 0);
    cascade_i = 1;
    selftest_i = 0; step();
    pop_chk("R6 resumes in order", 9'h0C1);

    // R5 bypass: ready indicator, storage frozen, flush ignored
    bypass_i = 1; tx_ready_i = 1; step();
    chk("R5 ready", {31'd0, empty_o}, 1);
    tx_ready_i = 0; step();
    chk("R5 not ready", {31'd0, empty_o}, 0);
    wr_en_i = 1; wr_data_i = 9'h0EE; rd_en_i = 1; flush_i = 1;
    repeat (12) step();
    idle(); flush_i = 0; step();
    chk("R5 no read in bypass", {31'd0, rd_valid_o}, 0);
    selftest_i = 1; st_done_i = 1; step(); st_done_i = 0;
    chk("R6 marker in bypass", {31'd0, empty_o}, 1);
    selftest_i = 0; bypass_i = 0; step();
    chk("R4 R5 flush ignored", {31'd0, empty_o}, 0);
    pop_chk("R5 contents kept", 9'h0C2);
    chk("R5 no write in bypass", {31'd0, empty_o}, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule